// File: doc/BRIEF.md
# Dual Byte-Lane Asynchronous SRAM Controller

This block sits between a synchronous host and an asynchronous static memory of 128K words by 16 bits. The memory has two active-low chip enables, one per byte, plus active-low write and output strobes. The host posts a one-cycle request that carries a word address, a two-bit lane mask, a direction flag and write data. The controller produces the strobe sequence, steers the data bus, and answers with a one-cycle done pulse and, for reads, the returned word.

Each phase lasts a whole number of clock cycles. That number is derived at elaboration from nanosecond timing parameters and the clock period. It is rounded up, with a floor of one cycle. Every access starts with one address setup cycle in which all strobes are high. A write always finishes by raising the write strobe while the chip enables are still low. Because of this, the shorter recovery and hold rules that apply to a write-strobe-terminated cycle are the ones that govern.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During and after reset, until a request arrives, both chip enables, the write strobe and the output strobe are high, the bus drive flag is low and done is low.
- R2: A read accepted in idle spends one setup cycle with all strobes high. It then holds the output strobe and the selected chip enables low, with the write strobe high, for RD_CYC cycles. RD_CYC is the rounded-up cycle count of the largest of read cycle, address access and output-enable access times: 14 cycles at the defaults.
- R3: Mask bit 1 selects the upper lane (data bits 15:8) through the upper chip enable. Mask bit 0 selects the lower lane (bits 7:0) through the lower chip enable. A lane that is not selected keeps its chip enable high and returns zero in the read data.
- R4: A write, after its setup cycle, holds the write strobe and the selected chip enables low for WP_CYC cycles, the larger of the rounded-up write pulse and data setup counts (11 at the defaults). The output strobe stays high throughout the write.
- R5: A write ends with one hold cycle in which the write strobe is high while the selected chip enables stay low and the write data is still driven. The chip enables rise at the next edge.
- R6: The controller drives the write data onto the bus only during the write pulse and the hold cycle. Whenever the bus drive flag is high, the driven value equals the request's write data. The bus is never driven while the output strobe is low.
- R7: After the chip enables rise, a write waits REC_CYC cycles with all strobes high. REC_CYC is the larger of the rounded-up write recovery count and the count that brings the whole write up to the write cycle time: 2 at the defaults.
- R8: The memory address equals the request's address from the setup cycle through the last cycle of the access, and it does not change while any chip enable is low.
- R9: A request with an all-zero mask raises done in the next cycle and produces no strobe or bus activity.
- R10: Done is high for exactly the one cycle after the last cycle of an access. The read data presented with it stays unchanged until the next read completes. A new request may be accepted in the same cycle that done is high.
- R11: A request that arrives while an access is in progress is ignored: it causes no strobe activity and no write to the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | One-cycle request strobe, taken only when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_mask | input | 2 | Lane mask: bit 1 upper byte, bit 0 lower byte |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 17 | Memory address |
| mem_ce_hi_n | output | 1 | Upper-byte chip enable, active low |
| mem_ce_lo_n | output | 1 | Lower-byte chip enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | 1 while the controller drives the data bus |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
Writes and reads are tried with each non-empty mask: the full word, the upper byte alone and the lower byte alone. The byte writes go on top of earlier full-word writes, so that reading back shows whether a lane outside the mask was disturbed. The memory model drives a recognisable filler on lanes it is not asked for, which separates correct masking of the read data from leakage. Addresses are chosen near both ends of the range. Further patterns are an all-zero mask in both directions, a request issued in the done cycle, and a stray request in the middle of a read. Together they tell the immediate-completion path, the back-to-back acceptance and the busy-ignore rule apart from the normal sequence, and every cycle's strobes, bus flag, address and done are compared against the step-counting model.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int CLK_NS  = 5,
  parameter int T_RC_NS = 70,
  parameter int T_AA_NS = 70,
  parameter int T_OE_NS = 35,
  parameter int T_WC_NS = 70,
  parameter int T_WP_NS = 55,
  parameter int T_DS_NS = 30,
  parameter int T_WR_NS = 5,
  parameter int AW      = 17,
  parameter int LANE_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req,
  input  logic                req_wr,
  input  logic [1:0]          req_mask,
  input  logic [AW-1:0]       req_addr,
  input  logic [2*LANE_W-1:0] req_wdata,
  output logic [2*LANE_W-1:0] rsp_rdata,
  output logic                rsp_done,
  output logic [AW-1:0]       mem_addr,
  output logic                mem_ce_hi_n,
  output logic                mem_ce_lo_n,
  output logic                mem_we_n,
  output logic                mem_oe_n,
  output logic [2*LANE_W-1:0] mem_dq_out,
  output logic                mem_dq_oe,
  input  logic [2*LANE_W-1:0] mem_dq_in
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int DW      = 2 * LANE_W;
  localparam int RD_CYC  = imax(cyc(T_RC_NS), imax(cyc(T_AA_NS), cyc(T_OE_NS)));
  localparam int WP_CYC  = imax(cyc(T_WP_NS), cyc(T_DS_NS));
  localparam int REC_CYC = imax(cyc(T_WR_NS), cyc(T_WC_NS) - WP_CYC - 1);
  localparam int MAX_CYC = imax(RD_CYC, imax(WP_CYC, REC_CYC));
  localparam int CW      = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_READ, ST_WRITE, ST_HOLD, ST_REC
  } state_t;

  state_t          state, state_d;
  logic [CW-1:0]   cnt, cnt_d;
  logic [AW-1:0]   addr_q;
  logic [1:0]      mask_q;
  logic            wr_q;
  logic [DW-1:0]   wdata_q;
  logic            take, skip, last;
  logic            lane_on, pulse_on, drive_on;

  assign take     = (state == ST_IDLE) && req && (req_mask != 2'b00);
  assign skip     = (state == ST_IDLE) && req && (req_mask == 2'b00);
  assign last     = (cnt == '0) && (state == ST_READ || state == ST_REC);
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;

  always_comb begin
    state_d = state;
    cnt_d   = cnt;
    case (state)
      ST_IDLE:  if (take) state_d = ST_SETUP;
      ST_SETUP: begin
        state_d = wr_q ? ST_WRITE : ST_READ;
        cnt_d   = wr_q ? CW'(WP_CYC - 1) : CW'(RD_CYC - 1);
      end
      ST_READ:  if (cnt == '0) state_d = ST_IDLE; else cnt_d = cnt - 1'b1;
      ST_WRITE: if (cnt == '0) state_d = ST_HOLD; else cnt_d = cnt - 1'b1;
      ST_HOLD: begin
        state_d = ST_REC;
        cnt_d   = CW'(REC_CYC - 1);
      end
      ST_REC:   if (cnt == '0) state_d = ST_IDLE; else cnt_d = cnt - 1'b1;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign lane_on  = (state_d == ST_READ) || (state_d == ST_WRITE) || (state_d == ST_HOLD);
  assign pulse_on = (state_d == ST_WRITE);
  assign drive_on = (state_d == ST_WRITE) || (state_d == ST_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      addr_q      <= '0;
      mask_q      <= 2'b00;
      wr_q        <= 1'b0;
      wdata_q     <= '0;
      rsp_rdata   <= '0;
      rsp_done    <= 1'b0;
      mem_ce_hi_n <= 1'b1;
      mem_ce_lo_n <= 1'b1;
      mem_we_n    <= 1'b1;
      mem_oe_n    <= 1'b1;
      mem_dq_oe   <= 1'b0;
    end else begin
      state    <= state_d;
      cnt      <= cnt_d;
      rsp_done <= last || skip;
      if (take) begin
        addr_q  <= req_addr;
        mask_q  <= req_mask;
        wr_q    <= req_wr;
        wdata_q <= req_wdata;
      end
      if (state == ST_READ && cnt == '0) begin
        rsp_rdata[DW-1:LANE_W] <= mask_q[1] ? mem_dq_in[DW-1:LANE_W] : '0;
        rsp_rdata[LANE_W-1:0]  <= mask_q[0] ? mem_dq_in[LANE_W-1:0]  : '0;
      end
      mem_ce_hi_n <= !(lane_on && mask_q[1]);
      mem_ce_lo_n <= !(lane_on && mask_q[0]);
      mem_we_n    <= !pulse_on;
      mem_oe_n    <= !(state_d == ST_READ);
      mem_dq_oe   <= drive_on;
    end
  end

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_hi_n,
  input logic          ce_lo_n,
  input logic          we_n,
  input logic          oe_n,
  input logic          dq_oe,
  input logic          done,
  input logic [AW-1:0] addr
);

  logic any_ce;
  assign any_ce = !ce_hi_n || !ce_lo_n;

  assert_oe_high_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n);

  assert_we_needs_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> any_ce);

  assert_we_rises_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> any_ce && dq_oe);

  assert_no_drive_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);

  assert_drive_ends_with_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |-> !any_ce && we_n);

  assert_rec_strobes_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce_hi_n) |-> we_n && oe_n);

  assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    any_ce && $past(any_ce) |-> $stable(addr));

  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !any_ce && we_n && oe_n && !dq_oe);

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ce_hi_n (mem_ce_hi_n),
  .ce_lo_n (mem_ce_lo_n),
  .we_n    (mem_we_n),
  .oe_n    (mem_oe_n),
  .dq_oe   (mem_dq_oe),
  .done    (rsp_done),
  .addr    (mem_addr)
);

// File: tb/test_sram_lane_ctrl.sv
`timescale 1ns/1ps
module test_sram_lane_ctrl;

  localparam int RD  = 14;   // 70 ns at 5 ns, the largest read time
  localparam int WP  = 11;   // 55 ns pulse beats 30 ns data setup
  localparam int REC = 2;    // 70 ns cycle minus pulse minus hold, beats 5 ns
  localparam int R_END = RD;
  localparam int W_END = WP + 1 + REC;

  logic        clk = 0, rst_n = 0;
  logic        req = 0, req_wr = 0;
  logic [1:0]  req_mask = 0;
  logic [16:0] req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic [15:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic        rsp_done, mem_ce_hi_n, mem_ce_lo_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [16:0] mem_addr;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sram_lane_ctrl i_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_mask(req_mask),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .rsp_done(rsp_done), .mem_addr(mem_addr), .mem_ce_hi_n(mem_ce_hi_n),
    .mem_ce_lo_n(mem_ce_lo_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // memory device model
  logic [15:0] dev [int];
  logic [15:0] dev_q = 16'hA5A5;
  assign mem_dq_in = dev_q;

  function automatic logic [15:0] dev_rd(input int a);
    return dev.exists(a) ? dev[a] : 16'h0000;
  endfunction

  always @(posedge clk) begin
    logic [15:0] w;
    w = dev_rd(int'(mem_addr));
    dev_q <= {(!mem_oe_n && mem_we_n && !mem_ce_hi_n) ? w[15:8] : 8'hA5,
              (!mem_oe_n && mem_we_n && !mem_ce_lo_n) ? w[7:0]  : 8'h5A};
  end

  always @(posedge mem_we_n) begin
    logic [15:0] w;
    w = dev_rd(int'(mem_addr));
    if (mem_ce_hi_n === 1'b0) w[15:8] = mem_dq_out[15:8];
    if (mem_ce_lo_n === 1'b0) w[7:0]  = mem_dq_out[7:0];
    if (mem_ce_hi_n === 1'b0 || mem_ce_lo_n === 1'b0) dev[int'(mem_addr)] = w;
  end

  // reference model: step counter since acceptance
  logic [15:0] shadow [int];
  int          t = -1;
  bit          m_wr, m_done, m_rd_done, m_zero;
  logic [1:0]  m_mask;
  logic [16:0] m_addr;
  logic [15:0] m_wdata, m_rdata;

  function automatic logic [15:0] sh_rd(input int a);
    return shadow.exists(a) ? shadow[a] : 16'h0000;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      t <= -1; m_done <= 0; m_rd_done <= 0; m_zero <= 0;
    end else begin
      m_done <= 0; m_rd_done <= 0; m_zero <= 0;
      if (t < 0) begin
        if (req) begin
          if (req_mask == 2'b00) begin
            m_done <= 1; m_zero <= 1;
          end else begin
            logic [15:0] s;
            s = sh_rd(int'(req_addr));
            t <= 0; m_wr <= req_wr; m_mask <= req_mask;
            m_addr <= req_addr; m_wdata <= req_wdata;
            if (req_wr) begin
              if (req_mask[1]) s[15:8] = req_wdata[15:8];
              if (req_mask[0]) s[7:0]  = req_wdata[7:0];
              shadow[int'(req_addr)] = s;
            end else begin
              m_rdata <= {req_mask[1] ? s[15:8] : 8'h00, req_mask[0] ? s[7:0] : 8'h00};
            end
          end
        end
      end else if (t == (m_wr ? W_END : R_END)) begin
        t <= -1; m_done <= 1; m_rd_done <= !m_wr;
      end else begin
        t <= t + 1;
      end
    end
  end

  function automatic string phase_tag();
    if (m_zero) return "R9";
    if (t < 0) return m_done ? "R10" : "R11";
    if (t == 0) return "R8";
    if (!m_wr) return "R2";
    if (t <= WP) return "R4";
    if (t == WP + 1) return "R5";
    return "R7";
  endfunction

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit act;
      logic [5:0] exp_v, got_v;
      act = (t >= 1) && (m_wr ? (t <= WP + 1) : (t <= RD));
      exp_v = {!(act && m_mask[1]), !(act && m_mask[0]),
               !(m_wr && t >= 1 && t <= WP), !(!m_wr && t >= 1 && t <= RD),
               (m_wr && t >= 1 && t <= WP + 1), m_done};
      got_v = {mem_ce_hi_n, mem_ce_lo_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_done};
      compared++;
      if (got_v !== exp_v) begin
        mismatched++;
        $display("FAIL %s (R3 lanes) t=%0d strobes{ceh,cel,we,oe,dqoe,done} got %b exp %b",
                 phase_tag(), t, got_v, exp_v);
      end
      if (t >= 0) begin
        compared++;
        if (mem_addr !== m_addr) begin
          mismatched++;
          $display("FAIL R8 t=%0d addr got %h exp %h", t, mem_addr, m_addr);
        end
      end
      if (mem_dq_oe === 1'b1) begin
        compared++;
        if (mem_dq_out !== m_wdata) begin
          mismatched++;
          $display("FAIL R6 bus data got %h exp %h", mem_dq_out, m_wdata);
        end
      end
      if (m_rd_done) begin
        compared++;
        if (rsp_rdata !== m_rdata) begin
          mismatched++;
          $display("FAIL R3 read data got %h exp %h", rsp_rdata, m_rdata);
        end
      end
    end
  end

  // called at a negedge; returns at the negedge where done is seen
  task automatic do_req(input bit wr, input logic [1:0] mask,
                        input logic [16:0] a, input logic [15:0] d);
    int guard = 0;
    req = 1; req_wr = wr; req_mask = mask; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 0;
    while (!rsp_done && guard < 100) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    compared++;
    if ({mem_ce_hi_n, mem_ce_lo_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_done} !== 6'b111100) begin
      mismatched++;
      $display("FAIL R1 reset outputs got %b exp 111100",
               {mem_ce_hi_n, mem_ce_lo_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_done});
    end
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1: still quiet with no request
    compared++;
    if ({mem_ce_hi_n, mem_ce_lo_n, mem_we_n, mem_oe_n, mem_dq_oe} !== 5'b11110) begin
      mismatched++;
      $display("FAIL R1 idle outputs got %b exp 11110",
               {mem_ce_hi_n, mem_ce_lo_n, mem_we_n, mem_oe_n, mem_dq_oe});
    end

    // R4 R5 R7: full-word writes near both address ends
    do_req(1, 2'b11, 17'h1FFFF, 16'hBEEF);
    do_req(1, 2'b11, 17'h00000, 16'h1234);
    // R2 R10: full read issued in the done cycle (back to back)
    do_req(0, 2'b11, 17'h1FFFF, 16'h0000);
    // R3: upper-only write on top, then reads by lane
    do_req(1, 2'b10, 17'h1FFFF, 16'hC3FF);
    do_req(0, 2'b01, 17'h1FFFF, 16'h0000);
    do_req(0, 2'b10, 17'h1FFFF, 16'h0000);
    do_req(0, 2'b11, 17'h1FFFF, 16'h0000);
    // R3: lower-only write then full read
    do_req(1, 2'b01, 17'h00000, 16'h0077);
    do_req(0, 2'b11, 17'h00000, 16'h0000);
    // R9: empty mask, read and write
    do_req(0, 2'b00, 17'h00ABC, 16'h0000);
    do_req(1, 2'b00, 17'h00000, 16'hFFFF);
    do_req(0, 2'b11, 17'h00000, 16'h0000);

    // R11: stray write request during a read
    req = 1; req_wr = 0; req_mask = 2'b11; req_addr = 17'h0AAAA; req_wdata = 0;
    @(negedge clk);
    req = 0;
    repeat (3) @(negedge clk);
    req = 1; req_wr = 1; req_mask = 2'b11; req_addr = 17'h0AAAA; req_wdata = 16'hDEAD;
    @(negedge clk);
    req = 0;
    while (!rsp_done) @(negedge clk);
    repeat (2) @(negedge clk);
    do_req(0, 2'b11, 17'h0AAAA, 16'h0000);

    // R6 R7: write then immediate read of the same word
    do_req(1, 2'b11, 17'h05555, 16'h5AA5);
    do_req(0, 2'b11, 17'h05555, 16'h0000);
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule